// File: doc/BRIEF.md
# Timer Input Capture Unit

This block stamps external events with the value of a running 16-bit timer. One of two event sources is chosen: a dedicated input pin, or the output of an analog comparator. The chosen source is brought into the clock domain by a synchroniser. It can optionally pass through a noise filter. An edge detector then fires on the selected polarity only. When the detector fires, the block copies the counter value into a capture register and raises a capture flag. The flag can drive an interrupt request.

Software reaches the 16-bit capture register over an 8-bit bus through a shared high-byte holding register. A read of the low byte latches the high byte, so the two halves always belong together. In timer modes that use the capture register as the counter's TOP value, software may load the register: the high byte first, then the low byte, which commits all 16 bits. In those modes, automatic capture is suppressed. The counter and the comparator are outside the block and arrive as inputs.

Top module: `capture_unit`

## Requirements
- R1: `src_sel_i` = 0 makes the pin `pin_i` the event source. `src_sel_i` = 1 makes the comparator `cmp_i` the event source. Changes on the unselected input cause no capture.
- R2: `rise_i` = 1 captures on a 0-to-1 change of the selected source. `rise_i` = 0 captures on a 1-to-0 change. The opposite change leaves the flag and the capture register untouched.
- R3: With the filter off, suppose an input change is present before clock edge k. The capture register then holds the value `count_i` had at edge k+2, from two synchroniser flops and one edge-detect stage.
- R4: `flag_o` goes to 1 on the same clock edge that loads the capture register.
- R5: A high pulse on `irq_ack_i` or on `flag_clr_i` clears `flag_o` on the next edge. A capture on that same edge wins and leaves the flag set.
- R6: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R7: `bus_rdata_o` shows the capture register's low byte when `bus_hi_i` = 0, and the holding register when `bus_hi_i` = 1. A read strobe with `bus_hi_i` = 0 copies the capture register's high byte into the holding register.
- R8: Writes take effect only when `mode_i` selects a TOP mode (bit `mode_i` of `TOP_MODES`, which by default covers modes 12 and 14). In a TOP mode, a high-byte write loads the holding register, and a low-byte write sets the capture register to {holding, data}. In other modes, writes change neither register. A write strobe has priority over a read strobe in the same cycle.
- R9: While `mode_i` selects a TOP mode, a qualifying edge neither loads the capture register nor sets the flag.
- R10: With `filt_en_i` = 1, a new level is accepted only after four consecutive equal synchronised samples. This moves the capture from edge k+2 to edge k+6, and a pulse shorter than four cycles produces no capture.
- R11: After reset, the flag, the capture register and the holding register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw capture pin |
| cmp_i | input | 1 | Comparator output |
| src_sel_i | input | 1 | Source select: 0 pin, 1 comparator |
| rise_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| filt_en_i | input | 1 | Noise filter enable |
| mode_i | input | MODE_W | Timer waveform mode |
| count_i | input | 2*BYTE_W | Current counter value |
| irq_en_i | input | 1 | Capture interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| flag_clr_i | input | 1 | Software write-one-to-clear of the flag |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_hi_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wdata_i | input | BYTE_W | Bus write data |
| bus_rdata_o | output | BYTE_W | Bus read data |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The assertions take four things for granted about the inputs:
- `mode_i` and the source, polarity and filter controls are held steady while an event is in flight.
- The two sources sit at the same level whenever the selection changes.
- Reset is released with both event inputs low, so the detector never sees a change that only comes from its reset value.
- A bus strobe lasts as long as the access it stands for.

The stimulus respects all four. It changes configuration only after a quiet gap of at least ten cycles and keeps the pin and the comparator level-matched before switching. It issues bus accesses as single-cycle strobes driven on the falling clock edge.

// File: rtl/capture_pkg.sv
package capture_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE  = 3'd0,
        BUS_RD_LO = 3'd1,
        BUS_RD_HI = 3'd2,
        BUS_WR_LO = 3'd3,
        BUS_WR_HI = 3'd4
    } bus_op_e;

    // Write strobe takes priority over read strobe.
    function automatic bus_op_e decode_bus(input logic rd, input logic wr, input logic hi);
        if (wr)      return hi ? BUS_WR_HI : BUS_WR_LO;
        else if (rd) return hi ? BUS_RD_HI : BUS_RD_LO;
        else         return BUS_IDLE;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic smp_i,
    output logic lvl_o
);
    localparam int HIST_W = SAMPLES - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              filt;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [SAMPLES-1:0] window;

    always_comb begin
        window    = {st_q.hist, smp_i};
        st_d      = st_q;
        st_d.hist = window[HIST_W-1:0];
        if (&window)       st_d.filt = 1'b1;
        else if (~|window) st_d.filt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = en_i ? st_q.filt : smp_i;

    // R10: the filtered level only ever moves to a value just seen on the input
    a_r10_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.filt) |-> ($past(smp_i) == st_q.filt));

endmodule

// File: rtl/cap_edge.sv
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic lvl_i,
    output logic evt_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        evt_o  = rise_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R2: an event always lands on the level named by the polarity select
    a_r2_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (lvl_i == rise_i));

    // R2: an event follows a level different from the one it reaches
    a_r2_change: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> ($past(lvl_i) != $past(prev_q)));

endmodule

// File: rtl/capture_unit.sv
module capture_unit
    import capture_pkg::*;
#(
    parameter int                BYTE_W       = 8,
    parameter int                MODE_W       = 4,
    parameter logic [(1<<MODE_W)-1:0] TOP_MODES = 16'h5000,
    parameter int                SYNC_STAGES  = 2,
    parameter int                FILT_SAMPLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_i,
    input  logic                  cmp_i,
    input  logic                  src_sel_i,
    input  logic                  rise_i,
    input  logic                  filt_en_i,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic [2*BYTE_W-1:0]   count_i,
    input  logic                  irq_en_i,
    input  logic                  irq_ack_i,
    input  logic                  flag_clr_i,
    input  logic                  bus_rd_i,
    input  logic                  bus_wr_i,
    input  logic                  bus_hi_i,
    input  logic [BYTE_W-1:0]     bus_wdata_i,
    output logic [BYTE_W-1:0]     bus_rdata_o,
    output logic                  flag_o,
    output logic                  irq_o
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int NSRC  = 2;

    typedef struct packed {
        logic [CNT_W-1:0]  icr;
        logic [BYTE_W-1:0] temp;
        logic              flag;
    } cap_state_t;

    cap_state_t st_d, st_q;

    logic [NSRC-1:0] src_sync;
    logic            src_lvl;
    logic            filt_lvl;
    logic            evt;
    logic            top_use;
    logic            cap_now;
    bus_op_e         bus_op;

    cap_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cmp_i, pin_i}),
        .q_o   (src_sync)
    );

    assign src_lvl = src_sel_i ? src_sync[1] : src_sync[0];

    cap_filter #(.SAMPLES(FILT_SAMPLES)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (filt_en_i),
        .smp_i (src_lvl),
        .lvl_o (filt_lvl)
    );

    cap_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_i),
        .lvl_i  (filt_lvl),
        .evt_o  (evt)
    );

    always_comb begin
        top_use = TOP_MODES[mode_i];
        cap_now = evt & ~top_use;
        bus_op  = decode_bus(bus_rd_i, bus_wr_i, bus_hi_i);

        st_d = st_q;
        case (bus_op)
            BUS_RD_LO: st_d.temp = st_q.icr[CNT_W-1:BYTE_W];
            BUS_WR_HI: if (top_use) st_d.temp = bus_wdata_i;
            BUS_WR_LO: if (top_use) st_d.icr  = {st_q.temp, bus_wdata_i};
            default:   ;
        endcase
        if (cap_now) st_d.icr = count_i;

        if (irq_ack_i || flag_clr_i) st_d.flag = 1'b0;
        if (cap_now)                 st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o = bus_hi_i ? st_q.temp : st_q.icr[BYTE_W-1:0];
    assign flag_o      = st_q.flag;
    assign irq_o       = st_q.flag & irq_en_i;

    // R3/R4: a capture loads the counter value and the flag on one edge
    a_r4_flag_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        cap_now |=> (flag_o && st_q.icr == $past(count_i)));

    // R5: acknowledge without a concurrent capture leaves the flag low
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack_i || flag_clr_i) && !evt) |=> !flag_o);

    // R7: a low-byte read latches the high half into the holding register
    a_r7_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && !bus_hi_i) |=> (st_q.temp == $past(st_q.icr[CNT_W-1:BYTE_W])));

    // R8: outside TOP modes only a capture changes the capture register
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!TOP_MODES[mode_i] && !evt) |=> $stable(st_q.icr));

    // R9: in TOP modes only a low-byte write changes the capture register
    a_r9_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (TOP_MODES[mode_i] && !(bus_wr_i && !bus_hi_i)) |=> $stable(st_q.icr));

    // R6: request is never raised with a clear flag
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && irq_en_i));

endmodule

// File: tb/tb_capture_unit.sv
module tb_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 0, cmp = 0, src_sel = 0, rise = 1, filt_en = 0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] cnt = 16'h12F0;
    logic        irq_en = 0, irq_ack = 0, flag_clr = 0;
    logic        bus_rd = 0, bus_wr = 0, bus_hi = 0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    capture_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cmp_i(cmp), .src_sel_i(src_sel),
        .rise_i(rise), .filt_en_i(filt_en), .mode_i(mode), .count_i(cnt),
        .irq_en_i(irq_en), .irq_ack_i(irq_ack), .flag_clr_i(flag_clr),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_hi_i(bus_hi),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: behaviour of the requirements, evaluated per edge
    logic [15:0] m_icr;
    logic [7:0]  m_temp;
    logic        m_flag;
    logic        m_prev, m_filt;
    logic        pin_dly[$], cmp_dly[$];
    int          run_len;
    logic        run_val;

    always @(posedge clk) begin
        logic s_now, lvl, evt, top, capt;
        logic [15:0] old_icr;
        logic [7:0]  old_temp;
        if (!rst_n) begin
            m_icr = 0; m_temp = 0; m_flag = 0; m_prev = 0; m_filt = 0;
            pin_dly = '{1'b0, 1'b0}; cmp_dly = '{1'b0, 1'b0};
            run_len = 0; run_val = 0;
        end else begin
            s_now = src_sel ? cmp_dly[0] : pin_dly[0];
            void'(pin_dly.pop_front()); pin_dly.push_back(pin);
            void'(cmp_dly.pop_front()); cmp_dly.push_back(cmp);
            lvl = filt_en ? m_filt : s_now;
            if (s_now == run_val) run_len++;
            else begin run_len = 1; run_val = s_now; end
            if (run_len >= 4) m_filt = s_now;
            evt = rise ? (lvl && !m_prev) : (!lvl && m_prev);
            m_prev = lvl;
            top = (mode == 4'd12) || (mode == 4'd14);
            capt = evt && !top;
            old_icr = m_icr; old_temp = m_temp;
            if (bus_wr) begin
                if (top) begin
                    if (bus_hi) m_temp = wdata;
                    else        m_icr = {old_temp, wdata};
                end
            end else if (bus_rd && !bus_hi) begin
                m_temp = old_icr[15:8];
            end
            if (capt) m_icr = cnt;
            if (irq_ack || flag_clr) m_flag = 0;
            if (capt) m_flag = 1;
        end
    end

    // Per-cycle comparison, two time units after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R4 R5 flag", flag, m_flag);
            chk("R6 irq", irq, m_flag & irq_en);
            chk("R7 rdata", rdata, bus_hi ? m_temp : m_icr[7:0]);
        end
    end

    always @(negedge clk) cnt = cnt + 16'd1;

    always begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a source at a falling edge; return the count seen at the next rising edge
    task automatic drive_src(input bit use_cmp, input logic val, output logic [15:0] v);
        @(negedge clk);
        if (use_cmp) cmp = val; else pin = val;
        #1 v = cnt;
    endtask

    task automatic read16(output logic [15:0] val);
        @(negedge clk);
        bus_rd = 1; bus_hi = 0;
        #2 val[7:0] = rdata;
        @(negedge clk);
        bus_hi = 1;
        #2 val[15:8] = rdata;
        @(negedge clk);
        bus_rd = 0; bus_hi = 0;
    endtask

    task automatic write16(input logic [15:0] val);
        @(negedge clk);
        bus_wr = 1; bus_hi = 1; wdata = val[15:8];
        @(negedge clk);
        bus_hi = 0; wdata = val[7:0];
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        logic [15:0] v, rd, last;
        wait_cyc(3);
        @(negedge clk) rst_n = 1;
        wait_cyc(2);
        // R11: reset state
        chk("R11 flag", flag, 0);
        chk("R11 irq", irq, 0);
        read16(rd);
        chk("R11 capture register", rd, 16'h0000);

        // R1 R2 R3 R4: rising pin edge, filter off
        drive_src(0, 1, v);
        wait_cyc(10);
        chk("R4 flag set", flag, 1);
        read16(rd);
        chk("R3 captured count", rd, v + 16'd2);
        last = rd;

        // R5 clear by software, then R2 opposite edge ignored
        pulse_clr();
        wait_cyc(1);
        chk("R5 flag cleared", flag, 0);
        drive_src(0, 0, v);
        wait_cyc(10);
        chk("R2 falling ignored flag", flag, 0);
        read16(rd);
        chk("R2 falling ignored value", rd, last);

        // R2 falling polarity
        @(negedge clk) rise = 0;
        drive_src(0, 1, v);
        wait_cyc(10);
        chk("R2 rising ignored", flag, 0);
        drive_src(0, 0, v);
        wait_cyc(10);
        chk("R2 falling flag", flag, 1);
        read16(rd);
        chk("R2 falling capture", rd, v + 16'd2);
        last = rd;

        // R1 comparator source; pin ignored
        pulse_clr();
        @(negedge clk) begin src_sel = 1; rise = 1; end
        drive_src(0, 1, v);
        wait_cyc(10);
        chk("R1 pin ignored flag", flag, 0);
        read16(rd);
        chk("R1 pin ignored value", rd, last);
        drive_src(1, 1, v);
        wait_cyc(10);
        chk("R1 comparator flag", flag, 1);
        read16(rd);
        chk("R1 comparator capture", rd, v + 16'd2);

        // R6 interrupt gate and acknowledge
        @(negedge clk) irq_en = 1;
        #1 chk("R6 irq raised", irq, 1);
        @(negedge clk) irq_ack = 1;
        @(negedge clk) irq_ack = 0;
        #1 chk("R5 ack clears", flag, 0);
        chk("R6 irq dropped", irq, 0);

        // R10 noise filter on comparator, falling polarity
        @(negedge clk) begin filt_en = 1; rise = 0; end
        wait_cyc(6);
        drive_src(1, 0, v);
        wait_cyc(1);
        drive_src(1, 1, v);
        wait_cyc(12);
        chk("R10 short pulse rejected", flag, 0);
        drive_src(1, 0, v);
        wait_cyc(12);
        chk("R10 flag after filter", flag, 1);
        read16(rd);
        chk("R10 filtered capture", rd, v + 16'd6);
        last = rd;

        // R9 no capture in TOP mode; R8 writes there only
        pulse_clr();
        @(negedge clk) begin filt_en = 0; mode = 4'd12; end
        drive_src(1, 1, v);
        wait_cyc(3);
        drive_src(1, 0, v);
        wait_cyc(10);
        chk("R9 no flag in TOP mode", flag, 0);
        read16(rd);
        chk("R9 register unchanged", rd, last);
        write16(16'hABCD);
        read16(rd);
        chk("R8 write in TOP mode", rd, 16'hABCD);
        @(negedge clk) mode = 4'd14;
        write16(16'h5A3C);
        read16(rd);
        chk("R8 write in second TOP mode", rd, 16'h5A3C);
        @(negedge clk) mode = 4'd0;
        write16(16'h1122);
        read16(rd);
        chk("R8 write ignored outside TOP", rd, 16'h5A3C);

        wait_cyc(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule